// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address under classic two-level paging without physical address extension. A request carries the linear address, whether the access is a write, whether it comes from user mode, the paging enable, the supervisor write-protect enable, the large-page enable, the directory base register and an address mask for the 1 MB wrap line. The walker fetches the directory entry and, for a small page, the table entry through a 32-bit memory port that uses a valid/ready handshake. It then reports the physical frame address, the read and write permissions, whether a 4 MB mapping was used, and either success or a page fault with its error code.

Along the way the walker keeps the accessed and dirty flags of the visited entries up to date and writes an entry back only when one of those flags changes. Write permission is granted only for an entry that is already dirty, so a caching structure above the walker that holds the result will send the first write to a clean page back through the walker, which then sets the dirty flag in memory.

Top module: `pg_walker`

## Requirements
- R1: With `pg_en` low, an accepted request completes with `phys_addr` equal to the linear address with bits 11:0 cleared and ANDed with `a20_mask`, `prot_rd` and `prot_wr` both 1, no fault, and no memory access.
- R2: The first memory read of a walk is at ((`cr3` with bits 11:0 cleared) + ((linear address >> 20) with bits 1:0 cleared)) AND `a20_mask`.
- R3: For a small page the second memory read is at ((directory entry with bits 11:0 cleared) + ((linear address >> 10) AND 0xFFC)) AND `a20_mask`.
- R4: A directory or table entry whose bit 0 (present) is 0 ends the walk with `fault` high and `fault_code` bit 0 low.
- R5: A directory entry with bit 7 set while `pse_en` is 1 ends the walk as a 4 MB page: `big_page` is 1, no table entry is read, and `phys_addr` is {entry bits 31:22, linear bits 21:12, 12 zero bits} ANDed with `a20_mask`.
- R6: The effective user flag (bit 2) and writable flag (bit 1) are the AND of both levels for a small page and the directory entry alone for a 4 MB page; a user access faults when the user flag is 0, a user write faults when the writable flag is 0, and a supervisor write faults when `wp_en` is 1 and the writable flag is 0.
- R7: Every visited entry gets bit 5 (accessed) set and the final entry of a permitted write also gets bit 6 (dirty) set; an entry is written back to the address it was read from only when its value changes, and the directory write-back of a small-page walk happens before the table entry is read.
- R8: On success `prot_wr` is 1 only when the final entry is dirty after the access and either the effective writable flag is 1 or the access is a supervisor access with `wp_en` low; on a fault `prot_rd`, `prot_wr`, `big_page` and `phys_addr` are 0.
- R9: On a fault `fault_code` bit 0 is 1 for a protection violation and 0 for a missing entry, bit 1 is the write flag and bit 2 the user flag of the request, and `fault_vec` is 14; without a fault `fault_code` and `fault_vec` are 0.
- R10: A small-page `phys_addr` is the table entry bits 31:12 with 12 zero bits below, ANDed with `a20_mask`.
- R11: A request is taken only while `req_ready` is 1; requests offered during a walk are ignored, `done` is high for exactly one cycle per request, and the result outputs hold their values until the next request is taken.
- R12: Once `mem_valid` is raised, it stays high with `mem_addr`, `mem_write` and `mem_wdata` unchanged until a cycle with `mem_ready` high, and no read is issued beyond what the walk needs (none, one or two reads).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request taken this cycle if offered |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| pg_en | input | 1 | Paging enabled |
| wp_en | input | 1 | Supervisor writes honour the writable flag |
| pse_en | input | 1 | 4 MB directory mappings enabled |
| cr3 | input | 32 | Page directory base |
| a20_mask | input | 32 | Mask applied to every entry address and to the result |
| mem_valid | output | 1 | Memory access requested |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| done | output | 1 | One-cycle completion strobe |
| phys_addr | output | 32 | Physical frame address |
| prot_rd | output | 1 | Read permitted |
| prot_wr | output | 1 | Write permitted |
| big_page | output | 1 | Result came from a 4 MB mapping |
| fault | output | 1 | Walk ended in a page fault |
| fault_code | output | 3 | Fault error code |
| fault_vec | output | 8 | Exception vector of the fault |

## Verification
The hardest situations to reach from the ports are the ones that depend on the flags already stored in memory: a walk that must write back the directory entry and then still read the table, a repeat walk that must not write anything, and a supervisor write to a read-only page that succeeds only while write protection is off. The bench keeps a sparse memory model whose contents evolve only through the walker's own write-backs, so sequences of requests to the same page walk it from clean to accessed to dirty, and a reference model computes the expected reads, writes and result from the memory state at the time of each request. Memory latency rotates between zero and two wait cycles, and one request is followed by extra requests offered mid-walk to show that they are dropped.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  // flag positions inside a directory or table entry
  localparam int FLG_PRESENT  = 0;
  localparam int FLG_WRITABLE = 1;
  localparam int FLG_USER     = 2;
  localparam int FLG_ACCESSED = 5;
  localparam int FLG_DIRTY    = 6;
  localparam int FLG_LARGE    = 7;

  // fault code layout
  localparam int FC_PROT  = 0;
  localparam int FC_WRITE = 1;
  localparam int FC_USER  = 2;

  localparam logic [7:0] PF_VECTOR = 8'd14;

  typedef enum logic [2:0] {
    W_IDLE   = 3'd0,
    W_RD_DIR = 3'd1,
    W_WB_DIR = 3'd2,
    W_RD_TBL = 3'd3,
    W_WB_TBL = 3'd4,
    W_FINISH = 3'd5
  } walk_state_t;
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 10,
  parameter int ENT_LOG   = 2
) (
  input  logic [PAGE_BITS+2*IDX_BITS-1:0] base_reg,
  input  logic [PAGE_BITS+2*IDX_BITS-1:0] lin,
  input  logic [PAGE_BITS+2*IDX_BITS-1:0] ent,
  input  logic [PAGE_BITS+2*IDX_BITS-1:0] wrap_mask,
  output logic [PAGE_BITS+2*IDX_BITS-1:0] dir_addr,
  output logic [PAGE_BITS+2*IDX_BITS-1:0] tbl_addr,
  output logic [PAGE_BITS+2*IDX_BITS-1:0] pa_flat,
  output logic [PAGE_BITS+2*IDX_BITS-1:0] pa_small,
  output logic [PAGE_BITS+2*IDX_BITS-1:0] pa_large
);
  localparam int AW      = PAGE_BITS + 2*IDX_BITS;
  localparam int DIR_LSB = PAGE_BITS + IDX_BITS;

  logic [AW-1:0] dir_off, tbl_off;

  // index scaled by the entry size, zero-extended to full width
  assign dir_off = AW'({lin[AW-1:DIR_LSB], {ENT_LOG{1'b0}}});
  assign tbl_off = AW'({lin[DIR_LSB-1:PAGE_BITS], {ENT_LOG{1'b0}}});

  assign dir_addr = ({base_reg[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}} + dir_off) & wrap_mask;
  assign tbl_addr = ({ent[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}} + tbl_off) & wrap_mask;

  assign pa_flat  = {lin[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}} & wrap_mask;
  assign pa_small = {ent[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}} & wrap_mask;
  assign pa_large = {ent[AW-1:DIR_LSB], lin[DIR_LSB-1:PAGE_BITS], {PAGE_BITS{1'b0}}} & wrap_mask;

  logic unused_low;
  assign unused_low = ^{base_reg[PAGE_BITS-1:0], lin[PAGE_BITS-1:0], ent[PAGE_BITS-1:0]};
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm #(
  parameter int EW = 32
) (
  input  logic [EW-1:0] ent,
  input  logic          eff_user,
  input  logic          eff_wr,
  input  logic          is_write,
  input  logic          is_user,
  input  logic          wp,
  output logic          prot_fault,
  output logic [EW-1:0] ent_upd,
  output logic          ent_changed,
  output logic          wr_grant
);
  import pgw_pkg::*;

  logic [EW-1:0] set_bits;

  always_comb begin
    prot_fault = (is_user && !eff_user) ||
                 (is_user && is_write && !eff_wr) ||
                 (!is_user && is_write && wp && !eff_wr);
    set_bits = '0;
    set_bits[FLG_ACCESSED] = 1'b1;
    set_bits[FLG_DIRTY]    = is_write;
    ent_upd     = ent | set_bits;
    ent_changed = (ent_upd != ent);
    // write access only once the page is dirty
    wr_grant = ent_upd[FLG_DIRTY] && (eff_wr || (!is_user && !wp));
  end
endmodule

// File: rtl/pg_walker.sv
module pg_walker #(
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 10,
  parameter int ENT_LOG   = 2,
  parameter int FC_W      = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [PAGE_BITS+2*IDX_BITS-1:0] req_addr,
  input  logic                           req_write,
  input  logic                           req_user,
  input  logic                           pg_en,
  input  logic                           wp_en,
  input  logic                           pse_en,
  input  logic [PAGE_BITS+2*IDX_BITS-1:0] cr3,
  input  logic [PAGE_BITS+2*IDX_BITS-1:0] a20_mask,
  output logic                           mem_valid,
  output logic                           mem_write,
  output logic [PAGE_BITS+2*IDX_BITS-1:0] mem_addr,
  output logic [PAGE_BITS+2*IDX_BITS-1:0] mem_wdata,
  input  logic                           mem_ready,
  input  logic [PAGE_BITS+2*IDX_BITS-1:0] mem_rdata,
  output logic                           done,
  output logic [PAGE_BITS+2*IDX_BITS-1:0] phys_addr,
  output logic                           prot_rd,
  output logic                           prot_wr,
  output logic                           big_page,
  output logic                           fault,
  output logic [FC_W-1:0]                fault_code,
  output logic [7:0]                     fault_vec
);
  import pgw_pkg::*;

  localparam int AW = PAGE_BITS + 2*IDX_BITS;

  walk_state_t st, st_n;

  logic [AW-1:0] lin_q, cr3_q, a20_q, dir_q;
  logic          wr_q, user_q, wp_q, pse_q, large_q;

  logic          mv_n, mw_n;
  logic [AW-1:0] ma_n, md_n;

  logic          res_upd, large_n, dir_ld;
  logic [AW-1:0] r_pa;
  logic          r_rd, r_wr, r_big, r_flt;
  logic [FC_W-1:0] r_code;

  // address generation sources: live request while idle, latched copy after
  logic          idle;
  logic [AW-1:0] src_lin, src_cr3, src_a20, src_ent;
  assign idle    = (st == W_IDLE);
  assign src_lin = idle ? req_addr : lin_q;
  assign src_cr3 = idle ? cr3      : cr3_q;
  assign src_a20 = idle ? a20_mask : a20_q;
  assign src_ent = (st == W_RD_DIR || st == W_RD_TBL) ? mem_rdata : dir_q;

  logic [AW-1:0] dir_addr, tbl_addr, pa_flat, pa_small, pa_large;

  pgw_addr_gen #(.PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS), .ENT_LOG(ENT_LOG)) u_agen (
    .base_reg (src_cr3),
    .lin      (src_lin),
    .ent      (src_ent),
    .wrap_mask(src_a20),
    .dir_addr (dir_addr),
    .tbl_addr (tbl_addr),
    .pa_flat  (pa_flat),
    .pa_small (pa_small),
    .pa_large (pa_large)
  );

  // effective flags: table level is combined with the latched directory entry
  logic          at_tbl, eff_u, eff_w;
  logic          p_fault, p_chg, p_grant;
  logic [AW-1:0] p_upd;
  assign at_tbl = (st == W_RD_TBL);
  assign eff_u  = mem_rdata[FLG_USER]     & (at_tbl ? dir_q[FLG_USER]     : 1'b1);
  assign eff_w  = mem_rdata[FLG_WRITABLE] & (at_tbl ? dir_q[FLG_WRITABLE] : 1'b1);

  pgw_perm #(.EW(AW)) u_perm (
    .ent        (mem_rdata),
    .eff_user   (eff_u),
    .eff_wr     (eff_w),
    .is_write   (wr_q),
    .is_user    (user_q),
    .wp         (wp_q),
    .prot_fault (p_fault),
    .ent_upd    (p_upd),
    .ent_changed(p_chg),
    .wr_grant   (p_grant)
  );

  logic [AW-1:0] acc_bit;
  always_comb begin
    acc_bit = '0;
    acc_bit[FLG_ACCESSED] = 1'b1;
  end

  logic [FC_W-1:0] code_np, code_pv;
  always_comb begin
    code_np = '0;
    code_np[FC_WRITE] = wr_q;
    code_np[FC_USER]  = user_q;
    code_pv = code_np;
    code_pv[FC_PROT] = 1'b1;
  end

  always_comb begin
    st_n    = st;
    mv_n    = mem_valid;
    mw_n    = mem_write;
    ma_n    = mem_addr;
    md_n    = mem_wdata;
    large_n = large_q;
    dir_ld  = 1'b0;
    res_upd = 1'b0;
    r_pa    = '0;
    r_rd    = 1'b0;
    r_wr    = 1'b0;
    r_big   = 1'b0;
    r_flt   = 1'b0;
    r_code  = '0;
    case (st)
      W_IDLE: begin
        if (req_valid) begin
          if (!pg_en) begin
            st_n = W_FINISH;
            res_upd = 1'b1;
            r_pa = pa_flat;
            r_rd = 1'b1;
            r_wr = 1'b1;
          end else begin
            st_n = W_RD_DIR;
            mv_n = 1'b1;
            mw_n = 1'b0;
            ma_n = dir_addr;
          end
        end
      end
      W_RD_DIR: begin
        if (mem_ready) begin
          dir_ld = 1'b1;
          if (!mem_rdata[FLG_PRESENT]) begin
            st_n = W_FINISH; mv_n = 1'b0;
            res_upd = 1'b1; r_flt = 1'b1; r_code = code_np;
          end else if (mem_rdata[FLG_LARGE] && pse_q) begin
            large_n = 1'b1;
            res_upd = 1'b1;
            if (p_fault) begin
              st_n = W_FINISH; mv_n = 1'b0;
              r_flt = 1'b1; r_code = code_pv;
            end else begin
              r_pa = pa_large; r_rd = 1'b1; r_wr = p_grant; r_big = 1'b1;
              if (p_chg) begin
                st_n = W_WB_DIR; mw_n = 1'b1; md_n = p_upd;
              end else begin
                st_n = W_FINISH; mv_n = 1'b0;
              end
            end
          end else begin
            large_n = 1'b0;
            if (!mem_rdata[FLG_ACCESSED]) begin
              st_n = W_WB_DIR; mw_n = 1'b1; md_n = mem_rdata | acc_bit;
            end else begin
              st_n = W_RD_TBL; ma_n = tbl_addr;
            end
          end
        end
      end
      W_WB_DIR: begin
        if (mem_ready) begin
          if (large_q) begin
            st_n = W_FINISH; mv_n = 1'b0; mw_n = 1'b0;
          end else begin
            st_n = W_RD_TBL; mw_n = 1'b0; ma_n = tbl_addr;
          end
        end
      end
      W_RD_TBL: begin
        if (mem_ready) begin
          res_upd = 1'b1;
          if (!mem_rdata[FLG_PRESENT]) begin
            st_n = W_FINISH; mv_n = 1'b0;
            r_flt = 1'b1; r_code = code_np;
          end else if (p_fault) begin
            st_n = W_FINISH; mv_n = 1'b0;
            r_flt = 1'b1; r_code = code_pv;
          end else begin
            r_pa = pa_small; r_rd = 1'b1; r_wr = p_grant;
            if (p_chg) begin
              st_n = W_WB_TBL; mw_n = 1'b1; md_n = p_upd;
            end else begin
              st_n = W_FINISH; mv_n = 1'b0;
            end
          end
        end
      end
      W_WB_TBL: begin
        if (mem_ready) begin
          st_n = W_FINISH; mv_n = 1'b0; mw_n = 1'b0;
        end
      end
      W_FINISH: st_n = W_IDLE;
      default:  st_n = W_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= W_IDLE;
      lin_q <= '0; cr3_q <= '0; a20_q <= '0; dir_q <= '0;
      wr_q <= 1'b0; user_q <= 1'b0; wp_q <= 1'b0; pse_q <= 1'b0; large_q <= 1'b0;
      mem_valid <= 1'b0; mem_write <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      phys_addr <= '0; prot_rd <= 1'b0; prot_wr <= 1'b0; big_page <= 1'b0;
      fault <= 1'b0; fault_code <= '0; fault_vec <= '0;
    end else begin
      st <= st_n;
      mem_valid <= mv_n; mem_write <= mw_n; mem_addr <= ma_n; mem_wdata <= md_n;
      large_q <= large_n;
      if (idle && req_valid) begin
        lin_q <= req_addr; cr3_q <= cr3; a20_q <= a20_mask;
        wr_q <= req_write; user_q <= req_user; wp_q <= wp_en; pse_q <= pse_en;
      end
      if (dir_ld) dir_q <= mem_rdata | acc_bit;
      if (res_upd) begin
        phys_addr  <= r_pa;
        prot_rd    <= r_rd;
        prot_wr    <= r_wr;
        big_page   <= r_big;
        fault      <= r_flt;
        fault_code <= r_code;
        fault_vec  <= r_flt ? PF_VECTOR : 8'd0;
      end
    end
  end

  assign req_ready = idle;
  assign done      = (st == W_FINISH);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));

  // R7
  wb_accessed_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_write |-> mem_wdata[FLG_ACCESSED]);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && req_ready);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready && !req_valid |=> $stable(phys_addr) && $stable(fault) && $stable(prot_wr));

  // R1
  flat_map_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready && req_valid && !pg_en |=> done && !mem_valid);

  // R8
  fault_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    done && fault |-> !prot_wr && !prot_rd);

  // R9
  fault_vec_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (fault_vec == (fault ? PF_VECTOR : 8'd0)));
endmodule

// File: tb/sim_pg_walker.sv
module sim_pg_walker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic        pg_en = 1'b0, wp_en = 1'b0, pse_en = 1'b0;
  logic [31:0] req_addr = '0, cr3 = '0, a20_mask = '1;
  logic        req_ready, mem_valid, mem_write, mem_ready = 1'b0, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0, phys_addr;
  logic        prot_rd, prot_wr, big_page, fault;
  logic [2:0]  fault_code;
  logic [7:0]  fault_vec;

  pg_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_user(req_user),
    .pg_en(pg_en), .wp_en(wp_en), .pse_en(pse_en), .cr3(cr3), .a20_mask(a20_mask),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .done(done), .phys_addr(phys_addr), .prot_rd(prot_rd), .prot_wr(prot_wr),
    .big_page(big_page), .fault(fault), .fault_code(fault_code), .fault_vec(fault_vec)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // sparse memory model
  logic [31:0] mem [int unsigned];
  int rd_cnt = 0, wr_cnt = 0, lat = 0, waitc = 0;
  logic [31:0] rd_log0 = '0, rd_log1 = '0;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    mem_ready = 1'b0;
    if (mem_valid) begin
      if (waitc >= lat) begin
        mem_ready = 1'b1;
        waitc = 0;
        lat = (lat + 1) % 3;
        if (mem_write) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = rdm(mem_addr);
          if (rd_cnt == 0) rd_log0 = mem_addr;
          if (rd_cnt == 1) rd_log1 = mem_addr;
          rd_cnt++;
        end
      end else begin
        waitc++;
      end
    end
  end

  typedef struct {
    logic [31:0] pa;
    bit rd, wr, big, flt;
    logic [2:0] code;
    int nrd, nwr;
    logic [31:0] a0, a1;
    string req;
  } exp_t;

  exp_t sb[$];
  int done_cnt = 0;

  function automatic exp_t model(input logic [31:0] a, input bit w, input bit u,
                                 input bit pg, input bit wp, input bit pse, input string req);
    exp_t e;
    logic [31:0] pdea, ptea, pde, pte, ent, nent;
    bit cu, cw;
    e.pa = 0; e.rd = 0; e.wr = 0; e.big = 0; e.flt = 0; e.code = 0;
    e.nrd = 0; e.nwr = 0; e.a0 = 0; e.a1 = 0; e.req = req;
    if (!pg) begin
      e.pa = a & 32'hFFFF_F000 & a20_mask; e.rd = 1; e.wr = 1;
      return e;
    end
    pdea = ((cr3 & ~32'hFFF) + ((a >> 20) & ~32'h3)) & a20_mask;
    e.a0 = pdea; e.nrd = 1;
    pde = rdm(pdea);
    if (!pde[0]) begin e.flt = 1; e.code = {u, w, 1'b0}; return e; end
    if (pde[7] && pse) begin
      cu = pde[2]; cw = pde[1]; ent = pde; e.big = 1;
      e.pa = ({pde[31:22], 22'b0} | (a & 32'h003F_F000)) & a20_mask;
    end else begin
      if (!pde[5]) e.nwr++;
      ptea = ((pde & ~32'hFFF) + ((a >> 10) & 32'hFFC)) & a20_mask;
      e.a1 = ptea; e.nrd = 2;
      pte = rdm(ptea);
      if (!pte[0]) begin e.flt = 1; e.code = {u, w, 1'b0}; return e; end
      cu = pde[2] & pte[2]; cw = pde[1] & pte[1]; ent = pte;
      e.pa = pte & 32'hFFFF_F000 & a20_mask;
    end
    if ((u && !cu) || (u && w && !cw) || (!u && w && wp && !cw)) begin
      e.flt = 1; e.code = {u, w, 1'b1}; e.pa = 0; e.big = 0;
      return e;
    end
    nent = ent | 32'h20 | (w ? 32'h40 : 32'h0);
    if (nent != ent) e.nwr++;
    e.rd = 1;
    e.wr = nent[6] && (cw || (!u && !wp));
    return e;
  endfunction

  // monitor: compare each completed walk against the queued expectation
  always @(negedge clk) begin
    if (!rst && done) begin
      exp_t e;
      done_cnt++;
      if (sb.size() == 0) begin
        chk(0, "R11", "unexpected done", 32'd1, 32'd0);
      end else begin
        e = sb.pop_front();
        chk(phys_addr == e.pa, "R10", {e.req, " phys_addr"}, phys_addr, e.pa);
        chk(prot_rd == e.rd, "R8", {e.req, " prot_rd"}, 32'(prot_rd), 32'(e.rd));
        chk(prot_wr == e.wr, "R8", {e.req, " prot_wr"}, 32'(prot_wr), 32'(e.wr));
        chk(big_page == e.big, "R5", {e.req, " big_page"}, 32'(big_page), 32'(e.big));
        chk(fault == e.flt, "R4", {e.req, " fault"}, 32'(fault), 32'(e.flt));
        chk(fault_code == e.code, "R9", {e.req, " fault_code"}, 32'(fault_code), 32'(e.code));
        chk(fault_vec == (e.flt ? 8'd14 : 8'd0), "R9", {e.req, " fault_vec"},
            32'(fault_vec), e.flt ? 32'd14 : 32'd0);
        chk(rd_cnt == e.nrd, "R12", {e.req, " read count"}, 32'(rd_cnt), 32'(e.nrd));
        chk(wr_cnt == e.nwr, "R7", {e.req, " write count"}, 32'(wr_cnt), 32'(e.nwr));
        if (e.nrd >= 1) chk(rd_log0 == e.a0, "R2", {e.req, " dir addr"}, rd_log0, e.a0);
        if (e.nrd >= 2) chk(rd_log1 == e.a1, "R3", {e.req, " tbl addr"}, rd_log1, e.a1);
      end
    end
  end

  task automatic issue(input logic [31:0] a, input bit w, input bit u, input bit pg,
                       input bit wp, input bit pse, input string req, input int extra);
    while (!req_ready) @(negedge clk);
    sb.push_back(model(a, w, u, pg, wp, pse, req));
    rd_cnt = 0; wr_cnt = 0;
    req_addr = a; req_write = w; req_user = u; pg_en = pg; wp_en = wp; pse_en = pse;
    req_valid = 1'b1;
    @(negedge clk);
    if (extra > 0) begin
      // offered while busy: must be dropped
      req_addr = 32'hDEAD_B000; pg_en = 1'b0;
      repeat (extra) @(negedge clk);
    end
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    int d0;
    cr3 = 32'h0001_0000;
    mem[32'h0001_0004] = 32'h0002_0007;   // dir idx 1: table at 0x20000, P W U
    mem[32'h0002_000C] = 32'h0055_5007;   // tbl idx 3: P W U, clean
    mem[32'h0002_0014] = 32'h0066_6005;   // tbl idx 5: read-only
    mem[32'h0002_0018] = 32'h0077_7025;   // tbl idx 6: read-only, accessed
    mem[32'h0002_001C] = 32'h0013_0067;   // tbl idx 7: dirty, accessed
    mem[32'h0001_0008] = 32'h0C00_0087;   // dir idx 2: 4 MB, P W U
    mem[32'h0001_000C] = 32'h1000_00A3;   // dir idx 3: 4 MB, supervisor only
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(req_ready == 1'b1, "R11", "ready after reset", 32'(req_ready), 32'd1);
    chk(done == 1'b0 && mem_valid == 1'b0, "R12", "idle after reset", 32'({done, mem_valid}), 32'd0);
    chk(phys_addr == 32'h0 && fault == 1'b0, "R11", "result after reset", phys_addr, 32'h0);

    issue(32'h1234_5678, 1, 1, 0, 1, 0, "R1 paging off", 0);
    issue(32'h0040_3123, 0, 1, 1, 0, 0, "R7 first read", 0);
    chk(rdm(32'h0001_0004) == 32'h0002_0027, "R7", "dir accessed set", rdm(32'h0001_0004), 32'h0002_0027);
    chk(rdm(32'h0002_000C) == 32'h0055_5027, "R7", "tbl accessed set", rdm(32'h0002_000C), 32'h0055_5027);
    d0 = done_cnt;
    issue(32'h0040_3FFF, 0, 1, 1, 0, 0, "R11 repeat with busy requests", 2);
    chk(done_cnt == d0 + 1, "R11", "one done per request", 32'(done_cnt - d0), 32'd1);
    held = phys_addr;
    repeat (4) @(negedge clk);
    chk(phys_addr == held, "R11", "result held", phys_addr, held);
    issue(32'h0040_3000, 1, 1, 1, 0, 0, "R8 user write sets dirty", 0);
    chk(rdm(32'h0002_000C) == 32'h0055_5067, "R7", "tbl dirty set", rdm(32'h0002_000C), 32'h0055_5067);
    issue(32'h0800_0000, 1, 1, 1, 0, 0, "R4 dir missing", 0);
    issue(32'h0040_4000, 0, 0, 1, 0, 0, "R4 tbl missing", 0);
    issue(32'h0040_5000, 1, 1, 1, 0, 0, "R6 user write read-only", 0);
    issue(32'h0040_5000, 1, 0, 1, 0, 0, "R6 supervisor write no wp", 0);
    issue(32'h0040_6000, 1, 0, 1, 1, 0, "R6 supervisor write with wp", 0);
    issue(32'h0040_6000, 0, 0, 1, 1, 0, "R8 clean read-only read", 0);
    issue(32'h0091_2345, 0, 1, 1, 0, 1, "R5 large page", 0);
    issue(32'h0091_2345, 1, 0, 1, 0, 1, "R5 large page write", 0);
    issue(32'h0091_2345, 0, 1, 1, 0, 0, "R5 large flag ignored without pse", 0);
    issue(32'h00C0_1000, 0, 1, 1, 0, 1, "R6 large page supervisor only", 0);
    a20_mask = 32'hFFEF_FFFF;
    issue(32'h0040_7000, 0, 0, 1, 1, 0, "R10 wrap mask", 0);
    issue(32'h0010_1ABC, 0, 0, 0, 0, 0, "R1 wrap mask flat", 0);
    a20_mask = 32'hFFFF_FFFF;
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule